// File: doc/BRIEF.md
# Linked-List Descriptor DMA Engine

This block is the data mover of a storage host controller. Software builds a chain of four-word descriptors in system memory. Each descriptor holds a configuration word, a buffer size, a buffer word address and the word address of the next descriptor. Software then programs the base word address of the chain, the total byte count and the direction, and starts the engine.

The engine fetches each descriptor and accepts it only while the ownership bit is set. It moves the buffer's words between the local data FIFO and memory in fixed bursts that are gated by the FIFO level. It then writes the configuration word back with ownership returned to software and, on a failure, the error bit set. After that it follows the link to the next descriptor. It stops after the descriptor flagged last, or when the byte count runs out. On stopping it raises a receive-done or transmit-done status unless that descriptor asked for silence. A missing descriptor and a bus error each raise their own status.

The controller is a six-state machine:

- IDLE waits for start.
- FETCH reads the four descriptor words.
- DECODE checks ownership and clips the buffer to the bytes remaining.
- ARM waits for the FIFO threshold, or goes straight to writeback once the buffer is used up.
- BEAT moves one burst.
- WBACK returns the configuration word, then goes to FETCH for the next descriptor or to IDLE.

The transitions are:

- IDLE to FETCH on start.
- FETCH to DECODE after the fourth word.
- FETCH to IDLE on a bus error.
- DECODE to IDLE when the ownership bit is clear.
- DECODE to ARM otherwise.
- ARM to BEAT when the threshold is met.
- ARM to WBACK when no words are left in the buffer.
- BEAT to ARM at the end of a burst.
- BEAT to WBACK on a bus error.
- WBACK to FETCH to continue the chain.
- WBACK to IDLE on stop or error.
- Any state to IDLE on soft reset.

Top module: `chain_dma_engine`

## Requirements
- R1: On start (control register, address 2, bit 0), the engine reads four words at word addresses P, P+1, P+2 and P+3. P is first the base register (address 0) and afterwards the next-descriptor word (the fourth word) of the previous descriptor. The second word's bits 12:2 give the buffer size in words, and the third word is the buffer word address.
- R2: If the fetched configuration word has bit 31 (ownership) clear, the engine raises `stat_unavail`, moves no data, writes nothing back and returns to idle.
- R3: After a descriptor is handled, its configuration word is written back with bit 31 cleared and all other bits unchanged, except bit 30 as in R10.
- R4: A descriptor whose size field is zero moves no data, is still written back, and the chain continues to the next descriptor.
- R5: The chain stops after the descriptor whose configuration bit 2 (last) is set. Later descriptors keep their ownership bit.
- R6: The total byte count (address 1, in bytes, a multiple of 4) limits the words moved. The buffer that exhausts it is clipped, and the chain stops after that descriptor.
- R7: In receive (control bit 2 = 0), each burst of min(8, words left in the buffer) words starts only when `fifo_level` is at least that burst length. Data is popped from the FIFO and written to consecutive word addresses of the buffer.
- R8: In transmit (control bit 2 = 1), a burst starts only when DEPTH minus `fifo_level` is at least the burst length. Words are read from consecutive buffer addresses and pushed to the FIFO in order.
- R9: On a normal stop, `stat_rx_done` (receive) or `stat_tx_done` (transmit) is set, unless bit 1 of the final descriptor's configuration word is set. All status bits clear on start.
- R10: A bus error raises `stat_fatal` and stops the engine. A bus error during data movement also writes the descriptor back with bit 30 set.
- R11: Writing control bit 1 (soft reset) returns the engine to idle. The reset pulse lasts one cycle and needs no clearing write.
- R12: A memory request holds its address steady until it is acknowledged. The FIFO is popped or pushed only on an acknowledged data beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 base, 1 byte count, 2 control |
| reg_wdata | input | 32 | Register write data |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Word address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request completed |
| mem_err | input | 1 | Bus error, valid with mem_ack |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| fifo_level | input | LW | Words currently held in the FIFO |
| fifo_rdata | input | 32 | FIFO head word (receive) |
| fifo_pop | output | 1 | Consume the head word |
| fifo_push | output | 1 | Write fifo_wdata into the FIFO |
| fifo_wdata | output | 32 | Word pushed in transmit |
| busy | output | 1 | Engine not idle |
| stat_rx_done | output | 1 | Receive chain completed |
| stat_tx_done | output | 1 | Transmit chain completed |
| stat_unavail | output | 1 | Descriptor not owned by the engine |
| stat_fatal | output | 1 | Bus error seen |

## Verification
The bench builds chains in which one descriptor is flagged last ahead of the end of the list, one buffer has zero size, and the byte count runs out partway through a buffer. A design that ignored the last flag would clear the ownership of descriptors beyond it. A design that stopped at a zero-size entry would lose the data after it, and one that did not clip would overwrite the sentinel words past the clip point. Holding the FIFO level one word short of a burst checks the thresholds: an engine with an off-by-one threshold moves data too early. Clearing the ownership bit, injecting a mid-buffer bus error and issuing a soft reset during a stall check that the engine stops cleanly with the right status and the right written-back error bit, where a careless design would hang, report done or restart with stale state.

// File: rtl/chain_dma_pkg.sv
package chain_dma_pkg;
    typedef enum logic [2:0] {
        S_IDLE, S_FETCH, S_DECODE, S_ARM, S_BEAT, S_WBACK
    } eng_state_t;

    localparam int OWN_BIT   = 31;
    localparam int FAULT_BIT = 30;
    localparam int LAST_BIT  = 2;
    localparam int QUIET_BIT = 1;

    localparam logic [1:0] REG_BASE  = 2'd0;
    localparam logic [1:0] REG_COUNT = 2'd1;
    localparam logic [1:0] REG_CTRL  = 2'd2;
endpackage

// File: rtl/dma_reg_block.sv
module dma_reg_block #(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          reg_we,
    input  logic [1:0]    reg_addr,
    input  logic [31:0]   reg_wdata,
    output logic [AW-1:0] base_waddr,
    output logic [CW-3:0] count_words,
    output logic          dir_tx,
    output logic          start_p,
    output logic          soft_rst_p
);
    import chain_dma_pkg::*;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_waddr  <= '0;
            count_words <= '0;
            dir_tx      <= 1'b0;
            start_p     <= 1'b0;
            soft_rst_p  <= 1'b0;
        end else begin
            start_p    <= reg_we && (reg_addr == REG_CTRL) && reg_wdata[0];
            soft_rst_p <= reg_we && (reg_addr == REG_CTRL) && reg_wdata[1];
            if (reg_we) begin
                unique case (reg_addr)
                    REG_BASE:  base_waddr  <= reg_wdata[AW-1:0];
                    REG_COUNT: count_words <= reg_wdata[CW-1:2];
                    REG_CTRL:  dir_tx      <= reg_wdata[2];
                    default:   ;
                endcase
            end
        end
    end
endmodule

// File: rtl/dma_burst_gate.sv
module dma_burst_gate #(
    parameter int DEPTH = 16,
    parameter int BURST = 8,
    localparam int LW  = $clog2(DEPTH + 1),
    localparam int BLW = $clog2(BURST + 1)
) (
    input  logic           dir_tx,
    input  logic [LW-1:0]  fifo_level,
    input  logic [10:0]    buf_left,
    output logic [BLW-1:0] burst_len,
    output logic           go
);
    localparam logic [LW-1:0]  DEPTH_L = LW'(DEPTH);
    localparam logic [BLW-1:0] BURST_L = BLW'(BURST);

    logic [LW-1:0] room;
    logic [LW-1:0] need;

    always_comb begin
        burst_len = (buf_left < 11'(BURST)) ? buf_left[BLW-1:0] : BURST_L;
        room      = DEPTH_L - fifo_level;
        need      = LW'(burst_len);
        go        = dir_tx ? (room >= need) : (fifo_level >= need);
    end
endmodule

// File: rtl/chain_dma_engine.sv
module chain_dma_engine #(
    parameter int AW    = 32,
    parameter int CW    = 16,
    parameter int DEPTH = 16,
    parameter int BURST = 8,
    localparam int LW   = $clog2(DEPTH + 1),
    localparam int BLW  = $clog2(BURST + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          reg_we,
    input  logic [1:0]    reg_addr,
    input  logic [31:0]   reg_wdata,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [31:0]   mem_wdata,
    input  logic          mem_ack,
    input  logic          mem_err,
    input  logic [31:0]   mem_rdata,
    input  logic [LW-1:0] fifo_level,
    input  logic [31:0]   fifo_rdata,
    output logic          fifo_pop,
    output logic          fifo_push,
    output logic [31:0]   fifo_wdata,
    output logic          busy,
    output logic          stat_rx_done,
    output logic          stat_tx_done,
    output logic          stat_unavail,
    output logic          stat_fatal
);
    import chain_dma_pkg::*;

    eng_state_t     state, nxt;
    logic [AW-1:0]  base_waddr, ptr, buf_addr, next_ptr;
    logic [CW-3:0]  count_words, rem;
    logic           dir_cfg, dir_q, start_p, soft_rst_p, fault_seen;
    logic [1:0]     widx;
    logic [31:0]    cfg_w;
    logic [10:0]    size_w, buf_left, take_w;
    logic [BLW-1:0] burst_len, beat_left;
    logic           go, stop_here;

    dma_reg_block #(.AW(AW), .CW(CW)) u_regs (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .base_waddr(base_waddr), .count_words(count_words),
        .dir_tx(dir_cfg), .start_p(start_p), .soft_rst_p(soft_rst_p)
    );

    dma_burst_gate #(.DEPTH(DEPTH), .BURST(BURST)) u_gate (
        .dir_tx(dir_q), .fifo_level(fifo_level), .buf_left(buf_left),
        .burst_len(burst_len), .go(go)
    );

    assign take_w    = (rem < (CW-2)'(size_w)) ? rem[10:0] : size_w;
    assign stop_here = cfg_w[LAST_BIT] || (rem == '0);

    // state register
    always_ff @(posedge clk) begin
        if (rst || soft_rst_p) state <= S_IDLE;
        else                   state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:   if (start_p) nxt = S_FETCH;
            S_FETCH:  if (mem_ack) nxt = mem_err ? S_IDLE : ((widx == 2'd3) ? S_DECODE : S_FETCH);
            S_DECODE: nxt = cfg_w[OWN_BIT] ? S_ARM : S_IDLE;
            S_ARM:    if (buf_left == '0) nxt = S_WBACK;
                      else if (go)        nxt = S_BEAT;
            S_BEAT:   if (mem_ack) begin
                          if (mem_err)                      nxt = S_WBACK;
                          else if (beat_left == BLW'(1))    nxt = S_ARM;
                      end
            S_WBACK:  if (mem_ack) nxt = (mem_err || fault_seen || stop_here) ? S_IDLE : S_FETCH;
            default:  nxt = S_IDLE;
        endcase
    end

    // datapath and status
    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0; buf_addr <= '0; next_ptr <= '0; rem <= '0; dir_q <= 1'b0;
            widx <= '0; cfg_w <= '0; size_w <= '0; buf_left <= '0; beat_left <= '0;
            fault_seen <= 1'b0; stat_rx_done <= 1'b0; stat_tx_done <= 1'b0;
            stat_unavail <= 1'b0; stat_fatal <= 1'b0;
        end else begin
            unique case (state)
                S_IDLE: if (start_p && !soft_rst_p) begin
                    ptr <= base_waddr; rem <= count_words; dir_q <= dir_cfg; widx <= '0;
                    fault_seen <= 1'b0; stat_rx_done <= 1'b0; stat_tx_done <= 1'b0;
                    stat_unavail <= 1'b0; stat_fatal <= 1'b0;
                end
                S_FETCH: if (mem_ack) begin
                    if (mem_err) stat_fatal <= 1'b1;
                    else begin
                        unique case (widx)
                            2'd0: cfg_w    <= mem_rdata;
                            2'd1: size_w   <= mem_rdata[12:2];
                            2'd2: buf_addr <= mem_rdata[AW-1:0];
                            default: next_ptr <= mem_rdata[AW-1:0];
                        endcase
                        widx <= widx + 2'd1;
                    end
                end
                S_DECODE: begin
                    if (!cfg_w[OWN_BIT]) stat_unavail <= 1'b1;
                    buf_left <= take_w;
                end
                S_ARM: if (go && buf_left != '0) beat_left <= burst_len;
                S_BEAT: if (mem_ack) begin
                    if (mem_err) begin
                        fault_seen <= 1'b1;
                        stat_fatal <= 1'b1;
                    end else begin
                        buf_addr  <= buf_addr + AW'(1);
                        buf_left  <= buf_left - 11'd1;
                        rem       <= rem - (CW-2)'(1);
                        beat_left <= beat_left - BLW'(1);
                    end
                end
                S_WBACK: if (mem_ack) begin
                    if (mem_err) stat_fatal <= 1'b1;
                    else if (!fault_seen) begin
                        if (stop_here) begin
                            if (!cfg_w[QUIET_BIT]) begin
                                if (dir_q) stat_tx_done <= 1'b1;
                                else       stat_rx_done <= 1'b1;
                            end
                        end else begin
                            ptr  <= next_ptr;
                            widx <= '0;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = ptr;
        mem_wdata = fifo_rdata;
        unique case (state)
            S_FETCH: begin mem_req = 1'b1; mem_addr = ptr + AW'(widx); end
            S_BEAT:  begin mem_req = 1'b1; mem_we = !dir_q; mem_addr = buf_addr; end
            S_WBACK: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = {1'b0, cfg_w[FAULT_BIT] | fault_seen, cfg_w[29:0]};
            end
            default: ;
        endcase
        fifo_pop   = (state == S_BEAT) && !dir_q && mem_ack && !mem_err;
        fifo_push  = (state == S_BEAT) &&  dir_q && mem_ack && !mem_err;
        fifo_wdata = mem_rdata;
        busy       = (state != S_IDLE);
    end
endmodule

// File: rtl/chain_dma_checker.sv
module chain_dma_checker #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          soft_rst_p,
    input logic          busy,
    input logic          mem_req,
    input logic          mem_ack,
    input logic [AW-1:0] mem_addr,
    input logic          fifo_pop,
    input logic          fifo_push,
    input logic          stat_rx_done,
    input logic          stat_tx_done,
    input logic          stat_unavail
);
    assert_req_held_R12: assert property (@(posedge clk) disable iff (rst || soft_rst_p)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    assert_fifo_on_ack_R12: assert property (@(posedge clk) disable iff (rst)
        (fifo_pop || fifo_push) |-> (mem_ack && $onehot0({fifo_pop, fifo_push})));

    assert_done_at_stop_R9: assert property (@(posedge clk) disable iff (rst)
        ($rose(stat_rx_done) || $rose(stat_tx_done)) |-> $fell(busy));

    assert_unavail_no_done_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(stat_unavail) |-> (!stat_rx_done && !stat_tx_done && !busy));

    assert_soft_reset_idle_R11: assert property (@(posedge clk) disable iff (rst)
        soft_rst_p |=> !busy);
endmodule

bind chain_dma_engine chain_dma_checker #(.AW(AW)) u_chk (
    .clk(clk), .rst(rst), .soft_rst_p(soft_rst_p), .busy(busy),
    .mem_req(mem_req), .mem_ack(mem_ack), .mem_addr(mem_addr),
    .fifo_pop(fifo_pop), .fifo_push(fifo_push), .stat_rx_done(stat_rx_done),
    .stat_tx_done(stat_tx_done), .stat_unavail(stat_unavail)
);

// File: tb/sim_chain_dma_engine.sv
module sim_chain_dma_engine;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic        mem_req, mem_we, mem_ack, mem_err;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic [4:0]  fifo_level = '0;
    logic [31:0] fifo_rdata, fifo_wdata;
    logic        fifo_pop, fifo_push, busy;
    logic        stat_rx_done, stat_tx_done, stat_unavail, stat_fatal;

    chain_dma_engine u0 (.*);

    // memory and FIFO models
    logic [31:0] mem [256];
    logic [31:0] tx_cap [256];
    int          tx_n, rx_seq;
    logic [31:0] err_addr = 32'hFFFF_FFFF;
    logic        bd_we = 1'b0, clr_cnt = 1'b0;
    logic [7:0]  bd_addr = '0;
    logic [31:0] bd_data = '0;

    assign fifo_rdata = 32'hA000_0000 | rx_seq;

    always @(posedge clk) begin
        if (rst) begin
            mem_ack <= 1'b0; mem_err <= 1'b0; mem_rdata <= '0;
        end else if (mem_req && !mem_ack) begin
            mem_ack   <= 1'b1;
            mem_err   <= (mem_addr == err_addr);
            mem_rdata <= mem[mem_addr[7:0]];
            if (mem_we && mem_addr != err_addr) mem[mem_addr[7:0]] <= mem_wdata;
        end else begin
            mem_ack <= 1'b0; mem_err <= 1'b0;
        end
        if (bd_we) mem[bd_addr] <= bd_data;
        if (clr_cnt) begin
            tx_n <= 0; rx_seq <= 0;
        end else begin
            if (fifo_pop) rx_seq <= rx_seq + 1;
            if (fifo_push) begin
                tx_cap[tx_n[7:0]] <= fifo_wdata;
                tx_n <= tx_n + 1;
            end
        end
    end

    int checks = 0, errors = 0, cycles = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++; checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic bd(input int a, input logic [31:0] d);
        @(negedge clk); bd_we = 1'b1; bd_addr = 8'(a); bd_data = d;
        @(negedge clk); bd_we = 1'b0;
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_we = 1'b0;
    endtask

    task automatic clean_mem();
        @(negedge clk); clr_cnt = 1'b1; err_addr = 32'hFFFF_FFFF;
        for (int w = 0; w < 256; w++) begin
            bd_we = 1'b1; bd_addr = 8'(w); bd_data = 32'hB000_0000 | w;
            @(negedge clk);
        end
        bd_we = 1'b0; clr_cnt = 1'b0;
    endtask

    // descriptor i at word 16+4i, buffer at 64+64i
    task automatic put_desc(input int i, input logic [31:0] cfg, input int size_b);
        bd(16 + 4*i, cfg);
        bd(17 + 4*i, 32'(size_b));
        bd(18 + 4*i, 32'(64 + 64*i));
        bd(19 + 4*i, 32'(20 + 4*i));
    endtask

    task automatic run(input bit dir, input int bytes);
        reg_write(2'd0, 32'd16);
        reg_write(2'd1, 32'(bytes));
        reg_write(2'd2, {29'd0, dir, 2'b01});
        repeat (3) @(negedge clk);
        for (int n = 0; n < 5000 && busy; n++) @(negedge clk);
        chk(!busy, "run completes", {31'd0, busy}, 32'd0);
    endtask

    typedef struct packed {
        logic        dir;
        logic [12:0] s0, s1, s2;
        logic [1:0]  last_at;
        logic [15:0] bc;
        logic        quiet;
    } case_t;

    localparam case_t CASES [5] = '{
        '{1'b0, 13'd32, 13'd32, 13'd32, 2'd1, 16'd1000, 1'b0},  // R5 last before end
        '{1'b1, 13'd40, 13'd0,  13'd24, 2'd2, 16'd1000, 1'b0},  // R4 zero-size skip
        '{1'b0, 13'd64, 13'd64, 13'd64, 2'd2, 16'd100,  1'b0},  // R6 count clip
        '{1'b1, 13'd12, 13'd8,  13'd4,  2'd2, 16'd1000, 1'b1},  // R9 quiet
        '{1'b0, 13'd4,  13'd36, 13'd8,  2'd0, 16'd1000, 1'b0}   // R1 single word
    };

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !mem_req, "R11 reset idle", {30'd0, busy, mem_req}, 32'd0);
        chk({stat_rx_done, stat_tx_done, stat_unavail, stat_fatal} == 4'd0, "R9 reset status",
            {28'd0, stat_rx_done, stat_tx_done, stat_unavail, stat_fatal}, 32'd0);

        for (int c = 0; c < 5; c++) begin
            case_t cs;
            int sz [3];
            int rem, seq, nt;
            bit proc [3];
            bit ok;
            logic [31:0] cfg [3];
            cs = CASES[c];
            sz[0] = int'(cs.s0); sz[1] = int'(cs.s1); sz[2] = int'(cs.s2);
            clean_mem();
            for (int i = 0; i < 3; i++) begin
                cfg[i] = 32'h8000_0010 | (i == 0 ? 32'h8 : 32'h0)
                       | (i == int'(cs.last_at) ? 32'h4 : 32'h0) | (cs.quiet ? 32'h2 : 32'h0);
                put_desc(i, cfg[i], sz[i]);
            end
            fifo_level = cs.dir ? 5'd0 : 5'd16;
            run(cs.dir, int'(cs.bc));
            rem = int'(cs.bc) / 4; seq = 0; nt = 0; ok = 1;
            for (int i = 0; i < 3; i++) proc[i] = 0;
            for (int i = 0; i < 3; i++) begin
                int words;
                words = (sz[i] / 4 < rem) ? sz[i] / 4 : rem;
                rem -= words;
                proc[i] = 1;
                for (int k = 0; k < 64; k++) begin
                    logic [31:0] a;
                    a = 32'(64 + 64*i + k);
                    if (!cs.dir) begin
                        if (k < words) begin
                            if (mem[a[7:0]] != (32'hA000_0000 | seq)) ok = 0;
                            seq++;
                        end else if (mem[a[7:0]] != (32'hB000_0000 | a)) ok = 0;
                    end else if (k < words) begin
                        if (tx_cap[nt[7:0]] != (32'hB000_0000 | a)) ok = 0;
                        nt++;
                    end
                end
                if (i == int'(cs.last_at) || rem == 0) break;
            end
            if (cs.dir) chk(tx_n == nt, "R8 transmit word count", 32'(tx_n), 32'(nt));
            chk(ok, cs.dir ? "R8 transmit data order" : "R7/R6 receive data and clip", {31'd0, ok}, 32'd1);
            for (int i = 0; i < 3; i++)
                chk(mem[16 + 4*i] == (proc[i] ? (cfg[i] & 32'h7FFF_FFFF) : cfg[i]),
                    "R3/R5 ownership writeback", mem[16 + 4*i],
                    proc[i] ? (cfg[i] & 32'h7FFF_FFFF) : cfg[i]);
            chk(stat_rx_done == (!cs.dir && !cs.quiet) && stat_tx_done == (cs.dir && !cs.quiet),
                "R9 done status", {30'd0, stat_rx_done, stat_tx_done},
                {30'd0, !cs.dir && !cs.quiet, cs.dir && !cs.quiet});
        end

        // R2: descriptor not owned
        clean_mem();
        put_desc(0, 32'h0000_001C, 32);
        fifo_level = 5'd16;
        run(1'b0, 1000);
        chk(stat_unavail && !stat_rx_done, "R2 unavailable status",
            {30'd0, stat_unavail, stat_rx_done}, 32'd2);
        chk(mem[16] == 32'h0000_001C && mem[64] == 32'hB000_0040, "R2 no writeback or data",
            mem[16], 32'h0000_001C);

        // R7: receive threshold, 7 words is short of an 8-word burst
        clean_mem();
        put_desc(0, 32'h8000_001C, 32);
        fifo_level = 5'd7;
        reg_write(2'd0, 32'd16); reg_write(2'd1, 32'd1000); reg_write(2'd2, 32'd1);
        repeat (40) @(negedge clk);
        chk(busy && mem[64] == 32'hB000_0040, "R7 holds below threshold", mem[64], 32'hB000_0040);
        fifo_level = 5'd8;
        for (int n = 0; n < 500 && busy; n++) @(negedge clk);
        chk(mem[71] == 32'hA000_0007 && stat_rx_done, "R7 burst after threshold", mem[71], 32'hA000_0007);

        // R8: transmit room threshold, 7 free of 16
        clean_mem();
        put_desc(0, 32'h8000_001C, 32);
        fifo_level = 5'd9;
        reg_write(2'd0, 32'd16); reg_write(2'd1, 32'd1000); reg_write(2'd2, 32'd5);
        repeat (40) @(negedge clk);
        chk(tx_n == 0 && busy, "R8 holds without room", 32'(tx_n), 32'd0);
        fifo_level = 5'd8;
        for (int n = 0; n < 500 && busy; n++) @(negedge clk);
        chk(tx_n == 8 && stat_tx_done, "R8 burst once room", 32'(tx_n), 32'd8);

        // R10: bus error on third data word
        clean_mem();
        put_desc(0, 32'h8000_001C, 32);
        err_addr = 32'd66;
        fifo_level = 5'd16;
        run(1'b0, 1000);
        chk(stat_fatal && !stat_rx_done, "R10 fatal status", {30'd0, stat_fatal, stat_rx_done}, 32'd2);
        chk(mem[16] == 32'h4000_001C, "R10 error bit written back", mem[16], 32'h4000_001C);
        chk(mem[65] == 32'hA000_0001 && mem[67] == 32'hB000_0043, "R10 stops after error",
            mem[67], 32'hB000_0043);

        // R11: soft reset during a stall, then a fresh start completes
        clean_mem();
        put_desc(0, 32'h8000_001C, 32);
        fifo_level = 5'd0;
        reg_write(2'd0, 32'd16); reg_write(2'd1, 32'd1000); reg_write(2'd2, 32'd1);
        repeat (10) @(negedge clk);
        chk(busy, "R11 stalled before reset", {31'd0, busy}, 32'd1);
        reg_write(2'd2, 32'd2);
        @(negedge clk);
        chk(!busy && !stat_rx_done, "R11 soft reset to idle", {30'd0, busy, stat_rx_done}, 32'd0);
        fifo_level = 5'd16;
        run(1'b0, 1000);
        chk(stat_rx_done && mem[71] == 32'hA000_0007, "R11 reset bit self-cleared", mem[71], 32'hA000_0007);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule